// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address into a physical address for one memory access: an instruction fetch, a data load or a data store of 1, 2 or 4 bytes. It sits beside a pipeline's address-generation stage. Each cycle it receives one request together with the current privilege level, the paging switch, the current address-space identifier, two direct-map window settings, the memory types used when paging is off, and a flat view of every entry of a paired-page translation table. One cycle later it presents the physical address and memory type, or an exception code together with the faulting virtual address.

The checks follow a fixed order. Alignment is checked first. Next comes the unpaged path, then the two direct-map windows in turn, then a block on user accesses to the upper half of the address space, then the table lookup, and last the valid, privilege and dirty checks on the page half that was selected. Each kind of access reports its own fault codes. The table storage, its maintenance operations, the bus transfer and the pipeline control are outside this block.

Top module: `va_xlate`

## Requirements
- R1: After reset every output is 0. `rsp_vld` is 1 exactly in the cycle after a cycle with `req_vld`=1, and the other outputs keep their values while no request arrives.
- R2: Alignment is checked first. `req_size` 0/1/2 means 1/2/4 bytes, and code 3 is treated as 4 bytes. A misaligned fetch (`req_type`=0) reports code 1. A misaligned load (type 1) or store (type 2) reports code 2. This holds whatever the paging, window and privilege settings are.
- R3: With `pg_en`=0 the physical address equals the virtual address. The memory type is `da_imat` for fetches and `da_dmat` for loads and stores.
- R4: Each window occupies 10 bits of `win_cfg`, with window 0 in the low bits. Its fields are virtual segment [9:7], physical segment [6:4], memory type [3:2], user enable [1] and kernel enable [0]. A window hits when va[31:29] equals its virtual segment and the enable for the current level is set (level 0 uses the kernel bit, level 3 the user bit; levels 1 and 2 never hit). The result is {physical segment, va[28:0]} with that window's memory type. Window 0 takes precedence over window 1.
- R5: A level-3 access with va[31]=1 that hits no window faults: code 1 for a fetch, code 3 for a load or store. Levels 0 to 2 are not blocked.
- R6: Each table entry is 89 bits wide, and entry i sits at bits [89*i +: 89]. Its fields are valid [88], global [87], identifier [86:77], virtual page pair number [76:58] (va[31:13]), page size [57:52], odd half [51:26] and even half [25:0]. A half holds valid [25], dirty [24], memory type [23:22], level [21:20] and frame number [19:0]. An entry matches when it is valid, it is global or its identifier equals `cur_asid`, its page size is 12 or 21, and its page-pair bits above the page size equal va[31:size+1]. Any other page size never matches.
- R7: When several entries match, the lowest-numbered one is used.
- R8: A paged access that reaches the lookup and finds no matching entry reports code 4.
- R9: va[size] selects the odd half when 1 and the even half when 0. If that half is not valid, the access reports code 5 for a fetch, 6 for a load or 7 for a store.
- R10: If the half is valid but the current level is numerically greater than the half's level, the access reports code 8.
- R11: A store to a half with dirty=0 reports code 9. The dirty bit has no effect on fetches and loads.
- R12: A successful lookup returns {frame number bits above the page size, va[size-1:0]} and the memory type of the selected half.
- R13: `rsp_ok` is 1 exactly when the code is 0. On a fault, `rsp_badva` holds the request address and `rsp_pa` and `rsp_mat` are 0. On success, `rsp_badva` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | A request is present this cycle |
| req_type | input | 2 | 0 fetch, 1 load, 2 store |
| req_va | input | 32 | Virtual address |
| req_size | input | 2 | log2 of the access size in bytes |
| cur_plv | input | 2 | Current privilege level |
| pg_en | input | 1 | Paged translation enabled |
| cur_asid | input | 10 | Current address-space identifier |
| win_cfg | input | 20 | Two direct-map windows, 10 bits each |
| da_imat | input | 2 | Memory type for unpaged fetches |
| da_dmat | input | 2 | Memory type for unpaged loads and stores |
| tlb_flat | input | 1424 | All table entries, 89 bits each |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 32 | Physical address |
| rsp_mat | output | 2 | Memory access type |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_xcode | output | 4 | Exception code, 0 for none |
| rsp_badva | output | 32 | Faulting virtual address |

## Verification
The only state is the response register, so any fault in the translation logic shows up in the response to the request that triggered it, exactly one cycle later. A wrong entry choice gives the wrong frame number in `rsp_pa`. A wrong step in the priority order gives the wrong code in `rsp_xcode`, for example a refill where an alignment or privilege fault was due. A wrong half selection gives the other half's memory type or fault. A stuck response register shows as `rsp_vld` out of step with `req_vld`, or as outputs that change while idle.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;
  localparam int VA_W   = 32;
  localparam int PPN_W  = 20;
  localparam int ASID_W = 10;
  localparam int VPPN_W = 19;
  localparam int PS_W   = 6;
  localparam int MAT_W  = 2;
  localparam int PLV_W  = 2;
  localparam int SEG_W  = 3;
  localparam int XC_W   = 4;

  localparam logic [PLV_W-1:0] PLV_KERN = 2'd0;
  localparam logic [PLV_W-1:0] PLV_USER = 2'd3;
  localparam logic [PS_W-1:0]  PS_SMALL = 6'd12;
  localparam logic [PS_W-1:0]  PS_LARGE = 6'd21;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;

  typedef enum logic [XC_W-1:0] {
    XC_NONE       = 4'd0,
    XC_FETCH_ADDR = 4'd1,
    XC_ALIGN      = 4'd2,
    XC_MEM_ADDR   = 4'd3,
    XC_REFILL     = 4'd4,
    XC_INV_FETCH  = 4'd5,
    XC_INV_LOAD   = 4'd6,
    XC_INV_STORE  = 4'd7,
    XC_PRIV       = 4'd8,
    XC_MODIFY     = 4'd9
  } xcode_e;

  typedef struct packed {
    logic             v;
    logic             d;
    logic [MAT_W-1:0] mat;
    logic [PLV_W-1:0] plv;
    logic [PPN_W-1:0] ppn;
  } pg_half_t;

  typedef struct packed {
    logic              e;
    logic              g;
    logic [ASID_W-1:0] asid;
    logic [VPPN_W-1:0] vppn;
    logic [PS_W-1:0]   ps;
    pg_half_t          odd;
    pg_half_t          even;
  } tlb_ent_t;

  typedef struct packed {
    logic [SEG_W-1:0] vseg;
    logic [SEG_W-1:0] pseg;
    logic [MAT_W-1:0] mat;
    logic             en_u;
    logic             en_k;
  } dmw_t;

  localparam int ENT_W = $bits(tlb_ent_t);
  localparam int WIN_W = $bits(dmw_t);

  // size code: 0 byte, 1 half, otherwise word
  function automatic logic misaligned(input logic [VA_W-1:0] va, input logic [1:0] size);
    case (size)
      2'd0:    return 1'b0;
      2'd1:    return va[0];
      default: return |va[1:0];
    endcase
  endfunction

  function automatic logic is_large(input logic [PS_W-1:0] ps);
    return ps == PS_LARGE;
  endfunction

  function automatic logic ent_match(input tlb_ent_t ent, input logic [VA_W-1:0] va,
                                     input logic [ASID_W-1:0] asid);
    logic tag_eq;
    tag_eq = is_large(ent.ps) ? (ent.vppn[VPPN_W-1:9] == va[VA_W-1:22])
                              : (ent.vppn == va[VA_W-1:13]);
    return ent.e && (ent.ps == PS_SMALL || ent.ps == PS_LARGE) &&
           (ent.g || ent.asid == asid) && tag_eq;
  endfunction

  function automatic logic odd_half(input logic [PS_W-1:0] ps, input logic [VA_W-1:0] va);
    return is_large(ps) ? va[21] : va[12];
  endfunction

  function automatic logic [VA_W-1:0] page_pa(input logic [PS_W-1:0] ps, input logic [PPN_W-1:0] ppn,
                                             input logic [VA_W-1:0] va);
    return is_large(ps) ? {ppn[PPN_W-1:9], va[20:0]} : {ppn, va[11:0]};
  endfunction
endpackage

// File: rtl/xl_dmw_match.sv
module xl_dmw_match import va_xlate_pkg::*; #(
  parameter int N_WIN = 2
) (
  input  logic [VA_W-1:0]        va,
  input  logic [PLV_W-1:0]       plv,
  input  logic [N_WIN*WIN_W-1:0] win_cfg,
  output logic                   hit,
  output logic [VA_W-1:0]        pa,
  output logic [MAT_W-1:0]       mat
);
  logic [N_WIN-1:0] hit_vec;

  for (genvar gw = 0; gw < N_WIN; gw++) begin : g_win
    dmw_t w;
    assign w = dmw_t'(win_cfg[gw*WIN_W +: WIN_W]);
    assign hit_vec[gw] = (va[VA_W-1 -: SEG_W] == w.vseg) &&
                         ((plv == PLV_KERN && w.en_k) || (plv == PLV_USER && w.en_u));
  end

  always_comb begin
    dmw_t sel;
    hit = 1'b0;
    sel = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (hit_vec[i] && !hit) begin
        hit = 1'b1;
        sel = dmw_t'(win_cfg[i*WIN_W +: WIN_W]);
      end
    end
    pa  = {sel.pseg, va[VA_W-SEG_W-1:0]};
    mat = sel.mat;
  end
endmodule

// File: rtl/xl_tlb_probe.sv
module xl_tlb_probe import va_xlate_pkg::*; #(
  parameter int N_ENT = 16
) (
  input  logic [VA_W-1:0]        va,
  input  logic [ASID_W-1:0]      asid,
  input  logic [N_ENT*ENT_W-1:0] tlb_flat,
  output logic                   found,
  output logic [N_ENT-1:0]       sel_oh,
  output tlb_ent_t               sel_ent
);
  logic [N_ENT-1:0] hit_vec;

  for (genvar ge = 0; ge < N_ENT; ge++) begin : g_ent
    tlb_ent_t ent_w;
    assign ent_w = tlb_ent_t'(tlb_flat[ge*ENT_W +: ENT_W]);
    assign hit_vec[ge] = ent_match(ent_w, va, asid);
  end

  // lowest index wins
  always_comb begin
    found   = 1'b0;
    sel_oh  = '0;
    sel_ent = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit_vec[i] && !found) begin
        found     = 1'b1;
        sel_oh[i] = 1'b1;
        sel_ent   = tlb_ent_t'(tlb_flat[i*ENT_W +: ENT_W]);
      end
    end
  end
endmodule

// File: rtl/va_xlate.sv
module va_xlate import va_xlate_pkg::*; #(
  parameter int N_ENT = 16,
  parameter int N_WIN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_vld,
  input  logic [1:0]             req_type,
  input  logic [VA_W-1:0]        req_va,
  input  logic [1:0]             req_size,
  input  logic [PLV_W-1:0]       cur_plv,
  input  logic                   pg_en,
  input  logic [ASID_W-1:0]      cur_asid,
  input  logic [N_WIN*WIN_W-1:0] win_cfg,
  input  logic [MAT_W-1:0]       da_imat,
  input  logic [MAT_W-1:0]       da_dmat,
  input  logic [N_ENT*ENT_W-1:0] tlb_flat,
  output logic                   rsp_vld,
  output logic [VA_W-1:0]        rsp_pa,
  output logic [MAT_W-1:0]       rsp_mat,
  output logic                   rsp_ok,
  output logic [XC_W-1:0]        rsp_xcode,
  output logic [VA_W-1:0]        rsp_badva
);
  // named internal events (observed by the bound checker)
  logic             misal;
  logic             win_hit;
  logic             user_hi_blk;
  logic             tlb_found;
  logic [N_ENT-1:0] tlb_sel_oh;

  logic [VA_W-1:0]  win_pa;
  logic [MAT_W-1:0] win_mat;
  tlb_ent_t         tlb_ent;
  pg_half_t         half;
  logic             is_fetch, is_store;

  logic [VA_W-1:0]  nx_pa;
  logic [MAT_W-1:0] nx_mat;
  xcode_e           nx_xc;

  assign is_fetch = (req_type == ACC_FETCH);
  assign is_store = (req_type == ACC_STORE);
  assign misal    = misaligned(req_va, req_size);

  xl_dmw_match #(.N_WIN(N_WIN)) u_win (
    .va(req_va), .plv(cur_plv), .win_cfg(win_cfg),
    .hit(win_hit), .pa(win_pa), .mat(win_mat)
  );

  xl_tlb_probe #(.N_ENT(N_ENT)) u_probe (
    .va(req_va), .asid(cur_asid), .tlb_flat(tlb_flat),
    .found(tlb_found), .sel_oh(tlb_sel_oh), .sel_ent(tlb_ent)
  );

  assign user_hi_blk = (cur_plv == PLV_USER) && req_va[VA_W-1] && !win_hit;
  assign half        = odd_half(tlb_ent.ps, req_va) ? tlb_ent.odd : tlb_ent.even;

  always_comb begin
    nx_pa  = '0;
    nx_mat = '0;
    nx_xc  = XC_NONE;
    if (misal) begin
      nx_xc = is_fetch ? XC_FETCH_ADDR : XC_ALIGN;
    end else if (!pg_en) begin
      nx_pa  = req_va;
      nx_mat = is_fetch ? da_imat : da_dmat;
    end else if (win_hit) begin
      nx_pa  = win_pa;
      nx_mat = win_mat;
    end else if (user_hi_blk) begin
      nx_xc = is_fetch ? XC_FETCH_ADDR : XC_MEM_ADDR;
    end else if (!tlb_found) begin
      nx_xc = XC_REFILL;
    end else if (!half.v) begin
      nx_xc = is_fetch ? XC_INV_FETCH : (is_store ? XC_INV_STORE : XC_INV_LOAD);
    end else if (cur_plv > half.plv) begin
      nx_xc = XC_PRIV;
    end else if (is_store && !half.d) begin
      nx_xc = XC_MODIFY;
    end else begin
      nx_pa  = page_pa(tlb_ent.ps, half.ppn, req_va);
      nx_mat = half.mat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_pa    <= '0;
      rsp_mat   <= '0;
      rsp_ok    <= 1'b0;
      rsp_xcode <= '0;
      rsp_badva <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_pa    <= nx_pa;
        rsp_mat   <= nx_mat;
        rsp_ok    <= (nx_xc == XC_NONE);
        rsp_xcode <= nx_xc;
        rsp_badva <= (nx_xc == XC_NONE) ? '0 : req_va;
      end
    end
  end
endmodule

// File: rtl/va_xlate_chk.sv
module va_xlate_chk import va_xlate_pkg::*; #(
  parameter int N_ENT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic [1:0]       req_type,
  input logic [VA_W-1:0]  req_va,
  input logic             pg_en,
  input logic             misal,
  input logic             win_hit,
  input logic             user_hi_blk,
  input logic             tlb_found,
  input logic [N_ENT-1:0] tlb_sel_oh,
  input logic             rsp_vld,
  input logic             rsp_ok,
  input logic [XC_W-1:0]  rsp_xcode,
  input logic [VA_W-1:0]  rsp_pa,
  input logic [MAT_W-1:0] rsp_mat
);
  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  a_r2_misalign_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && misal) |=> (rsp_xcode == XC_FETCH_ADDR || rsp_xcode == XC_ALIGN));
  a_r3_direct_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !misal && !pg_en) |=> (rsp_ok && rsp_pa == $past(req_va)));
  a_r5_user_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !misal && pg_en && user_hi_blk) |=> (!rsp_ok && !$past(win_hit)));
  a_r7_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_sel_oh) && (tlb_found == (tlb_sel_oh != '0)));
  a_r8_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !misal && pg_en && !win_hit && !user_hi_blk && !tlb_found)
      |=> (rsp_xcode == XC_REFILL));
  a_r11_modify_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_xcode == XC_MODIFY) |-> ($past(req_type) == ACC_STORE));
  a_r13_fault_clears_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_ok) |-> (rsp_pa == '0 && rsp_mat == '0));
  a_r13_badva_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && misal) |=> (!rsp_ok));
endmodule

bind va_xlate va_xlate_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_type(req_type), .req_va(req_va),
  .pg_en(pg_en), .misal(misal), .win_hit(win_hit), .user_hi_blk(user_hi_blk),
  .tlb_found(tlb_found), .tlb_sel_oh(tlb_sel_oh), .rsp_vld(rsp_vld), .rsp_ok(rsp_ok),
  .rsp_xcode(rsp_xcode), .rsp_pa(rsp_pa), .rsp_mat(rsp_mat)
);

// File: tb/va_xlate_tb_top.sv
module va_xlate_tb_top;
  import va_xlate_pkg::*;
  localparam int NE = 16;
  localparam int NW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req_vld = 1'b0;
  logic [1:0]      req_type = 2'd0;
  logic [31:0]     req_va = '0;
  logic [1:0]      req_size = 2'd0;
  logic [1:0]      cur_plv = 2'd0;
  logic            pg_en = 1'b0;
  logic [9:0]      cur_asid = '0;
  logic [1:0]      da_imat = 2'd0, da_dmat = 2'd0;
  dmw_t            w0 = '0, w1 = '0;
  tlb_ent_t        ents [NE];
  logic [NW*WIN_W-1:0] win_cfg;
  logic [NE*ENT_W-1:0] tlb_flat;

  logic        rsp_vld, rsp_ok;
  logic [31:0] rsp_pa, rsp_badva;
  logic [1:0]  rsp_mat;
  logic [3:0]  rsp_xcode;

  int n_chk = 0;
  int n_err = 0;

  assign win_cfg = {w1, w0};
  always_comb for (int i = 0; i < NE; i++) tlb_flat[i*ENT_W +: ENT_W] = ents[i];

  va_xlate #(.N_ENT(NE), .N_WIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_type(req_type), .req_va(req_va),
    .req_size(req_size), .cur_plv(cur_plv), .pg_en(pg_en), .cur_asid(cur_asid),
    .win_cfg(win_cfg), .da_imat(da_imat), .da_dmat(da_dmat), .tlb_flat(tlb_flat),
    .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_mat(rsp_mat), .rsp_ok(rsp_ok),
    .rsp_xcode(rsp_xcode), .rsp_badva(rsp_badva)
  );

  // drive at a falling edge, response is registered at the next rising edge,
  // sampled at the following falling edge
  task automatic probe(input string tag, input logic [1:0] ty, input logic [31:0] va,
                       input logic [1:0] sz, input logic [3:0] xc_e,
                       input logic [31:0] pa_e, input logic [1:0] mat_e);
    logic ok_e;
    logic [31:0] bva_e;
    ok_e  = (xc_e == 4'd0);
    bva_e = ok_e ? 32'd0 : va;
    if (!ok_e) begin pa_e = 32'd0; mat_e = 2'd0; end
    req_type = ty; req_va = va; req_size = sz; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    n_chk++;
    if (rsp_vld !== 1'b1 || rsp_ok !== ok_e || rsp_xcode !== xc_e || rsp_pa !== pa_e ||
        rsp_mat !== mat_e || rsp_badva !== bva_e) begin
      n_err++;
      $display("FAIL %s: got vld=%0b ok=%0b xc=%0d pa=%h mat=%0d bva=%h exp vld=1 ok=%0b xc=%0d pa=%h mat=%0d bva=%h",
               tag, rsp_vld, rsp_ok, rsp_xcode, rsp_pa, rsp_mat, rsp_badva,
               ok_e, xc_e, pa_e, mat_e, bva_e);
    end
  endtask

  task automatic t_reset_idle();
    n_chk++;
    if (rsp_vld !== 0 || rsp_ok !== 0 || rsp_xcode !== 0 || rsp_pa !== 0 || rsp_mat !== 0 || rsp_badva !== 0) begin
      n_err++;
      $display("FAIL R1 reset: got vld=%0b ok=%0b xc=%0d pa=%h exp all zero", rsp_vld, rsp_ok, rsp_xcode, rsp_pa);
    end
    pg_en = 1'b0; da_dmat = 2'd2;
    probe("R1 first", 2'd1, 32'h0000_1000, 2'd2, 4'd0, 32'h0000_1000, 2'd2);
    @(negedge clk);
    n_chk++;
    if (rsp_vld !== 1'b0 || rsp_pa !== 32'h0000_1000) begin
      n_err++;
      $display("FAIL R1 idle: got vld=%0b pa=%h exp vld=0 pa=00001000", rsp_vld, rsp_pa);
    end
  endtask

  task automatic t_align();
    pg_en = 1'b0;
    probe("R2 fetch", 2'd0, 32'h0000_1002, 2'd2, 4'd1, 0, 0);
    probe("R2 load half", 2'd1, 32'h0000_1001, 2'd1, 4'd2, 0, 0);
    probe("R2 store word", 2'd2, 32'h0000_1003, 2'd2, 4'd2, 0, 0);
    pg_en = 1'b1; cur_plv = 2'd3;
    probe("R2 before user block", 2'd1, 32'hC000_0002, 2'd2, 4'd2, 0, 0);
    pg_en = 1'b0; cur_plv = 2'd0; da_dmat = 2'd3;
    probe("R2 byte any addr", 2'd2, 32'h0000_1003, 2'd0, 4'd0, 32'h0000_1003, 2'd3);
  endtask

  task automatic t_direct();
    pg_en = 1'b0; da_imat = 2'd1; da_dmat = 2'd2; cur_plv = 2'd3;
    probe("R3 fetch", 2'd0, 32'h9000_1234, 2'd2, 4'd0, 32'h9000_1234, 2'd1);
    probe("R3 store", 2'd2, 32'h9000_1234, 2'd1, 4'd0, 32'h9000_1234, 2'd2);
  endtask

  task automatic t_windows();
    pg_en = 1'b1;
    w0 = '{vseg: 3'd5, pseg: 3'd0, mat: 2'd1, en_u: 1'b0, en_k: 1'b1};
    w1 = '{vseg: 3'd5, pseg: 3'd1, mat: 2'd2, en_u: 1'b1, en_k: 1'b1};
    cur_plv = 2'd0;
    probe("R4 window0 wins", 2'd1, 32'hA000_0010, 2'd2, 4'd0, 32'h0000_0010, 2'd1);
    cur_plv = 2'd3;
    probe("R4 user window1", 2'd1, 32'hA000_0010, 2'd2, 4'd0, 32'h2000_0010, 2'd2);
    cur_plv = 2'd1;
    probe("R4 R8 level1 misses", 2'd1, 32'hA000_0010, 2'd2, 4'd4, 0, 0);
    cur_plv = 2'd3;
    probe("R5 user load", 2'd1, 32'hC000_0000, 2'd2, 4'd3, 0, 0);
    probe("R5 user fetch", 2'd0, 32'hC000_0000, 2'd2, 4'd1, 0, 0);
    w0 = '0; w1 = '0;
  endtask

  task automatic t_tlb_small();
    tlb_ent_t e;
    logic [31:0] va_odd, va_even;
    va_odd = 32'h1234_5678; va_even = 32'h1234_4678;
    e = '0;
    e.e = 1; e.g = 0; e.asid = 10'd7; e.vppn = va_odd[31:13]; e.ps = 6'd12;
    e.odd  = '{v: 1'b1, d: 1'b0, mat: 2'd1, plv: 2'd3, ppn: 20'h000AB};
    e.even = '{v: 1'b1, d: 1'b1, mat: 2'd2, plv: 2'd0, ppn: 20'h00CD0};
    ents[3] = e;
    pg_en = 1'b1; cur_asid = 10'd7; cur_plv = 2'd3;
    probe("R12 odd load", 2'd1, va_odd, 2'd2, 4'd0, 32'h000A_B678, 2'd1);
    probe("R11 store clean", 2'd2, va_odd, 2'd2, 4'd9, 0, 0);
    probe("R10 even priv", 2'd1, va_even, 2'd2, 4'd8, 0, 0);
    cur_plv = 2'd0;
    probe("R12 even store", 2'd2, va_even, 2'd2, 4'd0, 32'h00CD_0678, 2'd2);
    cur_asid = 10'd8;
    probe("R6 asid miss", 2'd1, va_even, 2'd2, 4'd4, 0, 0);
    ents[3].g = 1'b1;
    probe("R6 global hit", 2'd1, va_even, 2'd2, 4'd0, 32'h00CD_0678, 2'd2);
    ents[3].ps = 6'd14;
    probe("R6 bad size", 2'd1, va_even, 2'd2, 4'd4, 0, 0);
    ents[3] = '0;
  endtask

  task automatic t_tlb_large();
    tlb_ent_t e;
    logic [31:0] va_o, va_e, exp_pa;
    va_o = 32'h4060_0ABC; va_e = 32'h4040_0ABC;
    e = '0;
    e.e = 1; e.g = 1; e.ps = 6'd21; e.vppn = {va_o[31:22], 9'h1FF};
    e.odd  = '{v: 1'b0, d: 1'b1, mat: 2'd0, plv: 2'd3, ppn: 20'h0};
    e.even = '{v: 1'b1, d: 1'b1, mat: 2'd3, plv: 2'd3, ppn: 20'h12E00};
    ents[5] = e;
    pg_en = 1'b1; cur_plv = 2'd0;
    probe("R9 invalid fetch", 2'd0, va_o, 2'd2, 4'd5, 0, 0);
    probe("R9 invalid load", 2'd1, va_o, 2'd2, 4'd6, 0, 0);
    probe("R9 invalid store", 2'd2, va_o, 2'd2, 4'd7, 0, 0);
    exp_pa = ((32'h12E00 >> 9) << 21) | (va_e & 32'h001F_FFFF);
    probe("R12 large even", 2'd0, va_e, 2'd2, 4'd0, exp_pa, 2'd3);
    ents[5] = '0;
  endtask

  task automatic t_lowest();
    tlb_ent_t e;
    logic [31:0] va;
    va = 32'h0800_1000;
    e = '0;
    e.e = 1; e.g = 1; e.ps = 6'd12; e.vppn = va[31:13];
    e.odd = '{v: 1'b1, d: 1'b1, mat: 2'd1, plv: 2'd3, ppn: 20'h22222};
    ents[9] = e;
    e.odd.ppn = 20'h11111;
    ents[8] = e;
    pg_en = 1'b1; cur_plv = 2'd0;
    probe("R7 lowest index", 2'd1, va, 2'd2, 4'd0, 32'h1111_1000, 2'd1);
    ents[8].e = 1'b0;
    probe("R7 next index", 2'd1, va, 2'd2, 4'd0, 32'h2222_2000, 2'd1);
    probe("R13 badva refill", 2'd1, 32'h0900_0000, 2'd2, 4'd4, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) ents[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_align();
    t_direct();
    t_windows();
    t_tlb_small();
    t_tlb_large();
    t_lowest();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule